// File: doc/BRIEF.md
# Shared Array Write Coordinator

Several independent thread state machines need to store 32-bit words into one shared two-dimensional register array. Each storage element can have only one write source. This block acts as the single writer on the threads' behalf. Each thread raises its request line and presents a data word and a row/column index pair. The coordinator picks one requester, writes its word into the addressed element and returns a per-thread acknowledge. It then waits until that thread withdraws its request before it serves anyone else.

The controller has two states. `WRC_SCAN` is the idle/arbitrate state. `WRC_HOLD` waits for the owner to release its request. There are two transitions:
- `grant`: from `WRC_SCAN` to `WRC_HOLD`, taken at a clock edge where at least one request is high.
- `release`: from `WRC_HOLD` to `WRC_SCAN`, taken at a clock edge where the owner's request is low.

Each write therefore occupies the coordinator for at least two cycles. Any element can also be read at any time through a combinational read port.

Top module: `shared_wr_coord`

## Requirements
- R1: While `rst` is high at a clock edge, every array element is cleared to zero, every `ack` bit goes low and the controller enters `WRC_SCAN`.
- R2: At a clock edge in `WRC_SCAN` with at least one request high, the chosen thread's `wr_data` is stored at its (`wr_row`, `wr_col`) element. Its `ack` bit (bit t for thread t) is high in the following cycle.
- R3: When several threads request in the same `WRC_SCAN` cycle, the lowest-numbered thread is granted. The others are served in later grants in ascending order while they keep requesting.
- R4: `ack` has at most one bit set. In `WRC_HOLD`, the owner's `ack` bit stays high for as long as its request stays high, and requests from other threads produce no acknowledge.
- R5: At an edge in `WRC_HOLD` where the owner's request is low, `ack` goes to zero and the controller returns to `WRC_SCAN` without granting. A waiting thread is therefore acknowledged two cycles after the owner drops its request.
- R6: A granted request whose row is not below ROWS, or whose column is not below COLS, changes no element, but the thread is still acknowledged as in R2.
- R7: `rd_data` shows, in the same cycle, the element at (`rd_row`, `rd_col`). It returns zero for an out-of-range index pair.
- R8: At most one element is written per clock edge. No element is written in a cycle spent in `WRC_HOLD`.
- R9: Data and indices are taken only at the grant edge. Changing the owner's `wr_data`, `wr_row` or `wr_col` during `WRC_HOLD` has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NP | Write request, bit t from thread t |
| wr_data | input | NP*DW | Write words, thread t in bits [t*DW +: DW] |
| wr_row | input | NP*RW | Row indices, thread t in bits [t*RW +: RW] |
| wr_col | input | NP*CW | Column indices, thread t in bits [t*CW +: CW] |
| ack | output | NP | Registered acknowledge, bit t to thread t |
| rd_row | input | RW | Read row index |
| rd_col | input | CW | Read column index |
| rd_data | output | DW | Element at (rd_row, rd_col), zero if out of range |

## Verification
The assertions assume that every thread follows the handshake: once a thread is acknowledged, it eventually lowers its request, and it does not raise the request again until it sees its `ack` drop. The hold assertion relies on the owner's request being a steady level, with no glitching while it is held.

The directed stimulus changes inputs only on falling edges. A modelled thread lowers its request in the same cycle its acknowledge is visible and does not raise it again until the acknowledge has cleared. Contention and out-of-range cases are produced by setting several request lines at once and by driving index values beyond the array bounds.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    typedef enum logic {
        WRC_SCAN = 1'b0,
        WRC_HOLD = 1'b1
    } wrc_state_e;
endpackage

// File: rtl/wrc_pick.sv
module wrc_pick #(
    parameter int NP = 4,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0] req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/wrc_fsm.sv
module wrc_fsm
    import wrc_pkg::*;
#(
    parameter int NP = 4,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] req,
    input  logic          pick_any,
    input  logic [IW-1:0] pick_idx,
    output logic          we,
    output logic [NP-1:0] ack
);
    wrc_state_e st_q, st_d;
    logic [IW-1:0] owner_q;
    logic          owner_req;

    assign owner_req = req[owner_q];
    assign we        = (st_q == WRC_SCAN) && pick_any;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WRC_SCAN: if (pick_any)   st_d = WRC_HOLD;
            WRC_HOLD: if (!owner_req) st_d = WRC_SCAN;
            default:                  st_d = WRC_SCAN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= WRC_SCAN;
            owner_q <= '0;
        end else begin
            st_q <= st_d;
            if (we) owner_q <= pick_idx;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= '0;
        end else begin
            unique case (st_q)
                WRC_SCAN: if (pick_any)   ack <= NP'(1) << pick_idx;
                WRC_HOLD: if (!owner_req) ack <= '0;
                default:                  ack <= '0;
            endcase
        end
    end

    // R4
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack));

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WRC_HOLD && owner_req) |=> $stable(ack));

    // R5
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WRC_HOLD && !owner_req) |=> (ack == '0));

    // R2
    grant_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == WRC_SCAN && (req != '0)) |=> $onehot(ack));

    // R8
    we_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);
endmodule

// File: rtl/wrc_store.sv
module wrc_store #(
    parameter int ROWS = 6,
    parameter int COLS = 7,
    parameter int DW   = 32,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RW-1:0] w_row,
    input  logic [CW-1:0] w_col,
    input  logic [DW-1:0] w_data,
    input  logic [RW-1:0] r_row,
    input  logic [CW-1:0] r_col,
    output logic [DW-1:0] r_data
);
    logic [COLS-1:0][DW-1:0] row_view [ROWS];
    logic w_ok;
    logic r_ok;

    assign w_ok = (int'(w_row) < ROWS) && (int'(w_col) < COLS);
    assign r_ok = (int'(r_row) < ROWS) && (int'(r_col) < COLS);

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic [COLS-1:0][DW-1:0] cells_q;
        logic                    hit;

        assign hit         = we && w_ok && (int'(w_row) == g);
        assign row_view[g] = cells_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cells_q <= '0;
            end else if (hit) begin
                cells_q[w_col] <= w_data;
            end
        end
    end

    always_comb begin
        r_data = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (r_ok && (int'(r_row) == i)) r_data = row_view[i][r_col];
        end
    end
endmodule

// File: rtl/shared_wr_coord.sv
module shared_wr_coord #(
    parameter int NP   = 4,
    parameter int ROWS = 6,
    parameter int COLS = 7,
    parameter int DW   = 32,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int IW  = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    req,
    input  logic [NP*DW-1:0] wr_data,
    input  logic [NP*RW-1:0] wr_row,
    input  logic [NP*CW-1:0] wr_col,
    output logic [NP-1:0]    ack,
    input  logic [RW-1:0]    rd_row,
    input  logic [CW-1:0]    rd_col,
    output logic [DW-1:0]    rd_data
);
    logic          pick_any;
    logic [IW-1:0] pick_idx;
    logic          we;
    logic [DW-1:0] sel_data;
    logic [RW-1:0] sel_row;
    logic [CW-1:0] sel_col;

    wrc_pick #(.NP(NP)) u_pick (
        .req (req),
        .any (pick_any),
        .idx (pick_idx)
    );

    wrc_fsm #(.NP(NP)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .we       (we),
        .ack      (ack)
    );

    assign sel_data = wr_data[pick_idx*DW +: DW];
    assign sel_row  = wr_row[pick_idx*RW +: RW];
    assign sel_col  = wr_col[pick_idx*CW +: CW];

    wrc_store #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .w_row  (sel_row),
        .w_col  (sel_col),
        .w_data (sel_data),
        .r_row  (rd_row),
        .r_col  (rd_col),
        .r_data (rd_data)
    );
endmodule

// File: tb/tb_shared_wr_coord.sv
module tb_shared_wr_coord;
    localparam int NP = 4;
    localparam int ROWS = 6;
    localparam int COLS = 7;
    localparam int DW = 32;
    localparam int RW = 3;
    localparam int CW = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic [NP-1:0]    req;
    logic [NP*DW-1:0] wr_data;
    logic [NP*RW-1:0] wr_row;
    logic [NP*CW-1:0] wr_col;
    logic [NP-1:0]    ack;
    logic [RW-1:0]    rd_row;
    logic [CW-1:0]    rd_col;
    logic [DW-1:0]    rd_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [ROWS][COLS];

    always #4 clk = ~clk;

    shared_wr_coord #(.NP(NP), .ROWS(ROWS), .COLS(COLS), .DW(DW)) dut (
        .clk(clk), .rst(rst), .req(req), .wr_data(wr_data), .wr_row(wr_row),
        .wr_col(wr_col), .ack(ack), .rd_row(rd_row), .rd_col(rd_col),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic rd(input int r, input int c, output logic [DW-1:0] v);
        rd_row = RW'(r);
        rd_col = CW'(c);
        #1;
        v = rd_data;
    endtask

    task automatic chk_cell(input string tag, input int r, input int c, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(r, c, v);
        chk(tag, 64'(v), 64'(exp));
    endtask

    task automatic chk_all(input string tag);
        int bad = 0;
        logic [DW-1:0] v;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                rd(r, c, v);
                if (v !== model[r][c]) bad++;
            end
        end
        chk(tag, 64'(bad), 64'd0);
    endtask

    task automatic drive(input int t, input logic on, input logic [DW-1:0] d,
                         input int r, input int c);
        req[t] = on;
        wr_data[t*DW +: DW] = d;
        wr_row[t*RW +: RW] = RW'(r);
        wr_col[t*CW +: CW] = CW'(c);
    endtask

    task automatic clear_model();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                model[r][c] = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        repeat (3) nxt();
        rst = 1'b0;
        clear_model();
        nxt();
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 ack after reset", 64'(ack), 64'd0);
        chk_all("R1 array zero after reset");
        rd(6, 0, v);
        chk("R7 out-of-range read is zero", 64'(v), 64'd0);
    endtask

    task automatic t_single();
        drive(2, 1'b1, 32'hCAFE_0001, 3, 4);
        nxt();
        chk("R2 ack for thread 2", 64'(ack), 64'h4);
        model[3][4] = 32'hCAFE_0001;
        chk_cell("R7 read-back of written element", 3, 4, 32'hCAFE_0001);
        req[2] = 1'b0;
        nxt();
        chk("R5 ack cleared after release", 64'(ack), 64'd0);
        chk_all("R2 single write array image");
    endtask

    task automatic t_contend();
        drive(0, 1'b1, 32'd22, 1, 2);
        drive(1, 1'b1, 32'd44, 5, 6);
        nxt();
        chk("R3 lowest thread granted first", 64'(ack), 64'h1);
        model[1][2] = 32'd22;
        chk_cell("R3 thread 0 element", 1, 2, 32'd22);
        chk_cell("R8 thread 1 element not yet written", 5, 6, model[5][6]);
        req[0] = 1'b0;
        nxt();
        chk("R5 no grant on release edge", 64'(ack), 64'd0);
        chk_cell("R8 still unwritten in gap", 5, 6, model[5][6]);
        nxt();
        chk("R5 waiting thread acked two cycles after drop", 64'(ack), 64'h2);
        model[5][6] = 32'd44;
        chk_cell("R3 thread 1 element", 5, 6, 32'd44);
        req[1] = 1'b0;
        nxt();
        chk("R5 ack cleared", 64'(ack), 64'd0);
        chk_all("R3 contention array image");
    endtask

    task automatic t_hold();
        drive(3, 1'b1, 32'h1234_5678, 0, 0);
        nxt();
        chk("R2 ack for thread 3", 64'(ack), 64'h8);
        model[0][0] = 32'h1234_5678;
        drive(3, 1'b1, 32'h0000_0055, 2, 2);
        drive(0, 1'b1, 32'h0000_0099, 4, 1);
        nxt();
        chk("R4 ack held while owner requests", 64'(ack), 64'h8);
        nxt();
        chk("R4 ack still held, other thread ignored", 64'(ack), 64'h8);
        chk_cell("R9 owner data change ignored", 2, 2, model[2][2]);
        chk_cell("R8 no write during hold", 4, 1, model[4][1]);
        chk_cell("R9 granted element kept", 0, 0, 32'h1234_5678);
        req[3] = 1'b0;
        nxt();
        chk("R5 release clears ack", 64'(ack), 64'd0);
        nxt();
        chk("R3 next requester granted", 64'(ack), 64'h1);
        model[4][1] = 32'h0000_0099;
        req[0] = 1'b0;
        nxt();
        chk_all("R9 hold array image");
    endtask

    task automatic t_range();
        drive(1, 1'b1, 32'hDEAD_BEEF, 6, 0);
        nxt();
        chk("R6 out-of-range row still acked", 64'(ack), 64'h2);
        req[1] = 1'b0;
        nxt();
        chk_all("R6 out-of-range row changed nothing");
        drive(2, 1'b1, 32'hBAD0_0002, 0, 7);
        nxt();
        chk("R6 out-of-range column still acked", 64'(ack), 64'h4);
        req[2] = 1'b0;
        nxt();
        chk("R6 ack cleared", 64'(ack), 64'd0);
        chk_all("R6 out-of-range column changed nothing");
        drive(3, 1'b1, 32'hF00D_0003, 5, 6);
        nxt();
        chk("R6 corner element write acked", 64'(ack), 64'h8);
        model[5][6] = 32'hF00D_0003;
        req[3] = 1'b0;
        nxt();
        chk_cell("R6 last valid element written", 5, 6, 32'hF00D_0003);
    endtask

    task automatic t_reset_hold();
        drive(0, 1'b1, 32'h7777_7777, 2, 3);
        nxt();
        chk("R2 ack before reset", 64'(ack), 64'h1);
        rst = 1'b1;
        req = '0;
        nxt();
        rst = 1'b0;
        clear_model();
        chk("R1 reset in hold clears ack", 64'(ack), 64'd0);
        chk_all("R1 reset in hold clears array");
        drive(1, 1'b1, 32'h0000_0101, 1, 1);
        nxt();
        chk("R1 controller back in scan after reset", 64'(ack), 64'h2);
        req[1] = 1'b0;
        nxt();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req = '0;
        wr_data = '0;
        wr_row = '0;
        wr_col = '0;
        rd_row = '0;
        rd_col = '0;
        nxt();
        do_reset();
        t_reset();
        t_single();
        t_contend();
        t_hold();
        t_range();
        t_reset_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule